// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Request Latch

This block turns a group of interrupt request lines into a registered vector of pending requests. Each line has its own bit in a trigger-mode register, which decides how that line is sensed. A line in level mode shows as pending for as long as its input is high. A line in edge mode latches a request on a low-to-high change of its input. That request stays latched until an acknowledge names the line. Priority resolution, masking and vector generation are done by downstream logic, which reads the pending vector and sends back an acknowledge strobe with the index of the line it has serviced.

The trigger-mode register can be written and read. A fixed parameter mask limits which of its bits can be set. Two clears are provided. A controller-init pulse clears the pending and previous-level state and leaves the trigger-mode register as it is. The asynchronous active-low hardware reset clears all state, including the trigger-mode register.

Top module: `irq_req_latch`

## Requirements
- R1: After hardware reset, `pend_o` is 0x00 and `trig_rdata_o` is 0x00.
- R2: A line whose trigger-mode bit is 1 (level mode) has its `pend_o` bit equal to that line's input as sampled at the previous clock edge, when there was no init.
- R3: A line whose trigger-mode bit is 0 (edge mode) sets its `pend_o` bit one cycle after its input is high while the stored previous level is low.
- R4: On an edge-mode line, a falling input leaves the `pend_o` bit unchanged. Only the stored previous level follows the input.
- R5: An acknowledge (`ack_i` high) to an edge-mode line with no new rising edge clears that line's `pend_o` bit one cycle later.
- R6: An acknowledge to a level-mode line does not change its `pend_o` bit, which keeps following the input.
- R7: A write stores `trig_wdata_i & WMASK` in the trigger-mode register, visible on `trig_rdata_o` one cycle later. With the default WMASK of 0xF8, bits 2..0 always read 0.
- R8: A controller-init cycle makes `pend_o` 0x00 and clears every stored previous level, so an edge-mode input held high across the init raises its request again one cycle later. The trigger-mode register is left unchanged.
- R9: When an acknowledge and a new rising edge reach the same edge-mode line in one cycle, the `pend_o` bit stays set.
- R10: Hardware reset asserted in the middle of operation clears the trigger-mode register as well as `pend_o`.
- R11: An acknowledge affects only the line selected by `ack_idx_i`. The `pend_o` bits of all other lines are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_i | input | N | Request lines, synchronous to clk |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| ack_idx_i | input | $clog2(N) | Index of the line being acknowledged |
| trig_wr_i | input | 1 | Trigger-mode register write enable |
| trig_wdata_i | input | N | Trigger-mode write data (1 = level, 0 = edge) |
| trig_rdata_o | output | N | Trigger-mode register contents |
| ctl_init_i | input | 1 | Controller-init clear pulse |
| pend_o | output | N | Pending request vector |

## Verification
The assertions assume that every input is synchronous to `clk` and that `ack_idx_i` is meaningful only while `ack_i` is high. Edge checks are held off for the cycle that follows an init, because the stored previous level is zero at that point. The bench drives every input one nanosecond after the rising edge, which keeps setup times clean. Its sweep draws requests, acknowledges, mode writes and inits from a pseudo-random generator, with writes and inits kept rare so that both sensing modes stay in place long enough for edges to be seen.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int          N     = 8,
  parameter logic [N-1:0] WMASK = 8'hF8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mode_q
);
  logic [N-1:0] mode_d;
  logic         mode_en;

  always_comb begin
    mode_en = wr_en;
    mode_d  = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec #(
  parameter int N = 8
) (
  input  logic                 ack_i,
  input  logic [$clog2(N)-1:0] idx_i,
  output logic [N-1:0]         ack_vec_o
);
  always_comb begin
    ack_vec_o = '0;
    if (ack_i) ack_vec_o[idx_i] = 1'b1;
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       ack_hit_i,
  input  logic       init_i,
  input  trig_mode_e mode_i,
  output logic       pend_o
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = req_i & ~prev_q;

  always_comb begin
    prev_d = init_i ? 1'b0 : req_i;
    if (init_i)                   pend_d = 1'b0;
    else if (mode_i == TRIG_LEVEL) pend_d = req_i;
    else if (rise)                 pend_d = 1'b1;   // new edge beats a same-cycle ack
    else if (ack_hit_i)            pend_d = 1'b0;
    else                           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int           N     = 8,
  parameter logic [N-1:0] WMASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic                 ack_i,
  input  logic [$clog2(N)-1:0] ack_idx_i,
  input  logic                 trig_wr_i,
  input  logic [N-1:0]         trig_wdata_i,
  output logic [N-1:0]         trig_rdata_o,
  input  logic                 ctl_init_i,
  output logic [N-1:0]         pend_o
);
  logic [N-1:0] mode_q;
  logic [N-1:0] ack_vec;

  irq_trig_reg #(.N(N), .WMASK(WMASK)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (trig_wr_i),
    .wdata  (trig_wdata_i),
    .mode_q (mode_q)
  );

  irq_ack_dec #(.N(N)) u_ack (
    .ack_i     (ack_i),
    .idx_i     (ack_idx_i),
    .ack_vec_o (ack_vec)
  );

  for (genvar g = 0; g < N; g++) begin : g_line
    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i[g]),
      .ack_hit_i (ack_vec[g]),
      .init_i    (ctl_init_i),
      .mode_i    (trig_mode_e'(mode_q[g])),
      .pend_o    (pend_o[g])
    );
  end

  assign trig_rdata_o = mode_q;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int           N     = 8,
  parameter logic [N-1:0] WMASK = 8'hF8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req_i,
  input logic                 ack_i,
  input logic [$clog2(N)-1:0] ack_idx_i,
  input logic                 trig_wr_i,
  input logic [N-1:0]         trig_wdata_i,
  input logic [N-1:0]         trig_rdata_o,
  input logic                 ctl_init_i,
  input logic [N-1:0]         pend_o
);
  // armed: at least one clock since reset, so $past never reaches into reset
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_init_i |=> ((pend_o & $past(trig_rdata_o)) == ($past(req_i) & $past(trig_rdata_o))));

  a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_init_i && !ack_i) |=> (($past(pend_o) & ~$past(trig_rdata_o) & ~pend_o) == '0));

  a_r7_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_i |=> (trig_rdata_o == ($past(trig_wdata_i) & WMASK)));

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rdata_o & ~WMASK) == '0);

  a_r8_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_init_i |=> (pend_o == '0));

  a_r8_init_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_init_i && !trig_wr_i) |=> $stable(trig_rdata_o));

  for (genvar g = 0; g < N; g++) begin : g_bit
    // R3 / R9: a rise on an edge line sets the bit, whether or not it is acknowledged
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(ctl_init_i) && !ctl_init_i && !trig_rdata_o[g]
       && req_i[g] && !$past(req_i[g])) |=> pend_o[g]);

    // R5: ack on an edge line without a new rise clears it
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(ctl_init_i) && !ctl_init_i && ack_i && (ack_idx_i == g)
       && !trig_rdata_o[g] && !(req_i[g] && !$past(req_i[g]))) |=> !pend_o[g]);
  end
endmodule

bind irq_req_latch irq_req_latch_chk #(.N(N), .WMASK(WMASK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .ack_i        (ack_i),
  .ack_idx_i    (ack_idx_i),
  .trig_wr_i    (trig_wr_i),
  .trig_wdata_i (trig_wdata_i),
  .trig_rdata_o (trig_rdata_o),
  .ctl_init_i   (ctl_init_i),
  .pend_o       (pend_o)
);

// File: tb/irq_req_latch_tb.sv
`timescale 1ns/1ps
module irq_req_latch_tb;
  localparam logic [7:0] MASK = 8'hF8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i;
  logic       ack_i;
  logic [2:0] ack_idx_i;
  logic       trig_wr_i;
  logic [7:0] trig_wdata_i;
  logic [7:0] trig_rdata_o;
  logic       ctl_init_i;
  logic [7:0] pend_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the requirements
  logic [7:0] m_pend, m_prev, m_trig;

  always #2 clk = ~clk;

  irq_req_latch u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .ack_i        (ack_i),
    .ack_idx_i    (ack_idx_i),
    .trig_wr_i    (trig_wr_i),
    .trig_wdata_i (trig_wdata_i),
    .trig_rdata_o (trig_rdata_o),
    .ctl_init_i   (ctl_init_i),
    .pend_o       (pend_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 8; i++) begin
      if (ctl_init_i) begin
        m_pend[i] = 1'b0;
      end else if (m_trig[i]) begin
        m_pend[i] = req_i[i];
      end else if (req_i[i] && !m_prev[i]) begin
        m_pend[i] = 1'b1;
      end else if (ack_i && ack_idx_i == 3'(i)) begin
        m_pend[i] = 1'b0;
      end
      m_prev[i] = ctl_init_i ? 1'b0 : req_i[i];
    end
    if (trig_wr_i) m_trig = trig_wdata_i & MASK;
  endtask

  // apply inputs (already 1 ns past an edge), advance one edge, sample 1 ns after
  task automatic step(input logic [7:0] rq, input logic ak, input logic [2:0] ix,
                      input logic wr, input logic [7:0] wd, input logic ini);
    req_i = rq; ack_i = ak; ack_idx_i = ix;
    trig_wr_i = wr; trig_wdata_i = wd; ctl_init_i = ini;
    model_step();
    @(posedge clk);
    #1;
  endtask

  task automatic hw_reset();
    req_i = '0; ack_i = 0; ack_idx_i = '0; trig_wr_i = 0; trig_wdata_i = '0; ctl_init_i = 0;
    rst_n = 1'b0;
    m_pend = '0; m_prev = '0; m_trig = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    hw_reset();
    chk("R1 pend after reset", pend_o, 8'h00);
    chk("R1 trig after reset", trig_rdata_o, 8'h00);

    step(8'h00, 0, 0, 1, 8'hFF, 0);
    chk("R7 masked write", trig_rdata_o, 8'hF8);      // lines 7..3 level, 2..0 edge

    step(8'h08, 0, 0, 0, 0, 0);
    chk("R2 level high", pend_o, 8'h08);
    step(8'h00, 0, 0, 0, 0, 0);
    chk("R2 level low", pend_o, 8'h00);

    step(8'h01, 0, 0, 0, 0, 0);
    chk("R3 edge rise", pend_o, 8'h01);
    step(8'h00, 0, 0, 0, 0, 0);
    chk("R4 edge fall keeps", pend_o, 8'h01);
    step(8'h00, 1, 3'd0, 0, 0, 0);
    chk("R5 ack clears edge", pend_o, 8'h00);

    step(8'h10, 0, 0, 0, 0, 0);
    step(8'h10, 1, 3'd4, 0, 0, 0);
    chk("R6 ack on level ignored", pend_o, 8'h10);

    step(8'h12, 1, 3'd1, 0, 0, 0);
    chk("R9 rise beats ack", pend_o, 8'h12);
    step(8'h12, 1, 3'd1, 0, 0, 0);
    chk("R5 ack without rise", pend_o, 8'h10);

    step(8'h11, 0, 0, 0, 0, 0);
    step(8'h11, 1, 3'd2, 0, 0, 0);
    chk("R11 ack other line", pend_o, 8'h11);

    step(8'h11, 0, 0, 0, 0, 1);
    chk("R8 init clears pend", pend_o, 8'h00);
    chk("R8 init keeps trig", trig_rdata_o, 8'hF8);
    step(8'h11, 0, 0, 0, 0, 0);
    chk("R8 prev cleared re-edge", pend_o, 8'h11);

    hw_reset();
    chk("R10 reset clears trig", trig_rdata_o, 8'h00);
    chk("R10 reset clears pend", pend_o, 8'h00);

    s = 32'h1234_5679;
    for (int n = 0; n < 4000; n++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      step(s[7:0], s[8], s[11:9], (s[15:12] == 4'h0), s[23:16], (s[29:24] == 6'h0));
      chk("R2 R3 R4 R5 R6 R9 R11 sweep pend", pend_o, m_pend);
      chk("R7 R8 sweep trig", trig_rdata_o, m_trig);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule